// File: doc/BRIEF.md
# Wakeup Source Debounce Controller

This block lives in an always-on domain that runs from a slow clock. It watches a set of external wakeup pins and a few internal alarm sources, and it raises a single wakeup request towards the core power supply. Each pin passes through a two-flop synchronizer and a per-pin enable mask. The masked pins are then ORed into one "pin active" level. A debounce counter must see that level stay high for a chosen number of consecutive slow-clock edges before the pins count as a wakeup.

A 3-bit debounce code in the mode register sets that number. The allowed lengths are not linear: code 0 means no filtering, and codes 1 to 5 step through 3, 32, 512, 4096 and 32768 cycles. The same register holds three separate enables for the RTC alarm, the real-time-timer alarm and the supply-monitor detection. A disabled source has no effect.

The wakeup request is a registered level. It stays high until the core domain pulses a clear strobe.

Top module: `wkup_dbnc_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00000000 and `wake_req` is 0.
- R2: A write stores only the debounce code (bits 14:12), the RTC enable (bit 3), the timer enable (bit 2) and the supply-monitor enable (bit 1). Every other bit reads back as zero, so the read mask is 0x0000700E. Without a write, the read value holds.
- R3: With debounce code 0, a pin seen high at a single slow-clock edge is enough. `wake_req` rises at the second edge after the edge that first captured the pin, because the synchronizer takes two flops and the request register takes one more edge.
- R4: With code 1, 2, 3, 4 or 5, a pin held high for N consecutive sampling edges raises `wake_req`, where N is 3, 32, 512, 4096 or 32768 in that order. A pin held for N-1 edges does not raise it. `wake_req` rises N+1 edges after the first capturing edge.
- R5: Codes 6 and 7 behave exactly like code 5 (32768 edges).
- R6: The debounce count restarts from zero whenever no enabled pin is active, so an interrupted pulse does not add up. Once the count reaches its threshold, it stops there.
- R7: Pin i counts only when `wkup_pin_en[i]` is 1. The enabled pins are ORed, so activity that moves from one enabled pin to another without a gap counts as one continuous pulse.
- R8: An alarm input that is high at a clock edge sets `wake_req` at that same edge, but only if its enable bit is 1. The RTC alarm uses bit 3, the timer alarm uses bit 2 and the supply monitor uses bit 1. A disabled alarm has no effect.
- R9: `wake_req` stays high until `wake_clr` is sampled high, and then it falls at that edge. If any enabled source is requesting at that same edge, the request wins and `wake_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Mode register write strobe |
| reg_wr_data | input | 32 | Mode register write data |
| reg_rd_data | output | 32 | Mode register read value (unused bits zero) |
| wkup_pin | input | NUM_PINS | Asynchronous wakeup pins, active high |
| wkup_pin_en | input | NUM_PINS | Per-pin enable mask |
| rtc_alarm | input | 1 | RTC alarm level or pulse |
| rtt_alarm | input | 1 | Real-time-timer alarm level or pulse |
| supmon_det | input | 1 | Supply-monitor detection |
| wake_clr | input | 1 | Clear strobe from the core domain |
| wake_req | output | 1 | Registered wakeup request level |

## Verification
Pin results are due N+1 rising edges after the first edge that captures the pin, where N is 1 for code 0 and the table length otherwise. Alarm and clear results show up right after the edge that samples them, and register writes read back after their edge. The bench drives every input just after a falling edge and samples just after later falling edges. Each pulse-length vector waits four extra edges after the pin drops before it checks the result, which is past the latest edge on which the request could rise. The latency checks, by contrast, count edges exactly and confirm the request is still low one edge before it is due.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;
   localparam int          MODE_W      = 32;
   localparam int          DBC_LSB     = 12;
   localparam int          DBC_W       = 3;
   localparam int          EN_RTC_BIT  = 3;
   localparam int          EN_RTT_BIT  = 2;
   localparam int          EN_SUP_BIT  = 1;
   localparam logic [31:0] MODE_MASK   = 32'h0000_700E;

   typedef enum logic [DBC_W-1:0] {
      DBC_NONE = 3'd0,
      DBC_LEN1 = 3'd1,
      DBC_LEN2 = 3'd2,
      DBC_LEN3 = 3'd3,
      DBC_LEN4 = 3'd4,
      DBC_LEN5 = 3'd5,
      DBC_ALT6 = 3'd6,
      DBC_ALT7 = 3'd7
   } dbc_code_e;

   typedef struct packed {
      dbc_code_e code;
      logic      rtc_en;
      logic      rtt_en;
      logic      sup_en;
   } mode_t;
endpackage

// File: rtl/wkup_sync.sv
`timescale 1ns/1ps
module wkup_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkup_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("wkup_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q[0] <= '0;
      end else begin
         stage_q[0] <= d;
      end
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wkup_mode_reg.sv
`timescale 1ns/1ps
module wkup_mode_reg
   import wkup_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output logic [MODE_W-1:0] rd_data,
   output mode_t             mode
);
   mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '{code: DBC_NONE, rtc_en: 1'b0, rtt_en: 1'b0, sup_en: 1'b0};
      end else if (wr_en) begin
         mode_q.code   <= dbc_code_e'(wr_data[DBC_LSB +: DBC_W]);
         mode_q.rtc_en <= wr_data[EN_RTC_BIT];
         mode_q.rtt_en <= wr_data[EN_RTT_BIT];
         mode_q.sup_en <= wr_data[EN_SUP_BIT];
      end
   end

   always_comb begin
      rd_data                      = '0;
      rd_data[DBC_LSB +: DBC_W]    = mode_q.code;
      rd_data[EN_RTC_BIT]          = mode_q.rtc_en;
      rd_data[EN_RTT_BIT]          = mode_q.rtt_en;
      rd_data[EN_SUP_BIT]          = mode_q.sup_en;
   end

   assign mode = mode_q;
endmodule

// File: rtl/wkup_dbnc.sv
`timescale 1ns/1ps
module wkup_dbnc
   import wkup_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int LEN1  = 3,
   parameter int LEN2  = 32,
   parameter int LEN3  = 512,
   parameter int LEN4  = 4096,
   parameter int LEN5  = 32768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  dbc_code_e        code,
   output logic             hit,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] thr
);
   localparam logic [CNT_W-1:0] T0 = CNT_W'(1);
   localparam logic [CNT_W-1:0] T1 = CNT_W'(LEN1);
   localparam logic [CNT_W-1:0] T2 = CNT_W'(LEN2);
   localparam logic [CNT_W-1:0] T3 = CNT_W'(LEN3);
   localparam logic [CNT_W-1:0] T4 = CNT_W'(LEN4);
   localparam logic [CNT_W-1:0] T5 = CNT_W'(LEN5);

   generate
      if (LEN5 >= (2 ** CNT_W)) begin : g_bad_cnt
         $error("wkup_dbnc: CNT_W too narrow for LEN5");
      end
      if (!(LEN1 >= 1 && LEN1 <= LEN2 && LEN2 <= LEN3 && LEN3 <= LEN4 && LEN4 <= LEN5))
      begin : g_bad_order
         $error("wkup_dbnc: lengths must be positive and ascending");
      end
   endgenerate

   always_comb begin
      unique case (code)
         DBC_NONE: thr = T0;
         DBC_LEN1: thr = T1;
         DBC_LEN2: thr = T2;
         DBC_LEN3: thr = T3;
         DBC_LEN4: thr = T4;
         default:  thr = T5;
      endcase
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (cnt_q < thr) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else begin
         cnt_q <= thr;
      end
   end

   assign cnt = cnt_q;
   assign hit = active && (cnt_q >= (thr - CNT_W'(1)));
endmodule

// File: rtl/wkup_dbnc_ctrl.sv
`timescale 1ns/1ps
module wkup_dbnc_ctrl
   import wkup_pkg::*;
#(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16,
   parameter int LEN1        = 3,
   parameter int LEN2        = 32,
   parameter int LEN3        = 512,
   parameter int LEN4        = 4096,
   parameter int LEN5        = 32768
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic [31:0]         reg_wr_data,
   output logic [31:0]         reg_rd_data,
   input  logic [NUM_PINS-1:0] wkup_pin,
   input  logic [NUM_PINS-1:0] wkup_pin_en,
   input  logic                rtc_alarm,
   input  logic                rtt_alarm,
   input  logic                supmon_det,
   input  logic                wake_clr,
   output logic                wake_req
);
   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("wkup_dbnc_ctrl: NUM_PINS must be at least 1");
      end
   endgenerate

   mode_t               mode;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] pin_masked;
   logic                pin_active;
   logic                pin_hit;
   logic [CNT_W-1:0]    dbnc_cnt;
   logic [CNT_W-1:0]    dbnc_thr;
   logic                alarm_set;
   logic                set_any;
   logic                wake_q;

   wkup_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_data (reg_wr_data),
      .rd_data (reg_rd_data),
      .mode    (mode)
   );

   wkup_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wkup_pin),
      .q     (pin_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
         assign pin_masked[p] = pin_sync[p] & wkup_pin_en[p];
      end
   endgenerate

   assign pin_active = |pin_masked;

   wkup_dbnc #(
      .CNT_W (CNT_W),
      .LEN1  (LEN1),
      .LEN2  (LEN2),
      .LEN3  (LEN3),
      .LEN4  (LEN4),
      .LEN5  (LEN5)
   ) u_dbnc (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (pin_active),
      .code   (mode.code),
      .hit    (pin_hit),
      .cnt    (dbnc_cnt),
      .thr    (dbnc_thr)
   );

   assign alarm_set = (rtc_alarm  & mode.rtc_en)
                    | (rtt_alarm  & mode.rtt_en)
                    | (supmon_det & mode.sup_en);
   assign set_any   = alarm_set | pin_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
      end else if (set_any) begin
         wake_q <= 1'b1;
      end else if (wake_clr) begin
         wake_q <= 1'b0;
      end
   end

   assign wake_req = wake_q;
endmodule

// File: rtl/wkup_dbnc_ctrl_chk.sv
`timescale 1ns/1ps
module wkup_dbnc_ctrl_chk
   import wkup_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int LEN5  = 32768
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [31:0]      reg_wr_data,
   input logic [31:0]      reg_rd_data,
   input logic             rtc_alarm,
   input logic             rtt_alarm,
   input logic             supmon_det,
   input logic             wake_clr,
   input logic             wake_req,
   input logic             pin_active,
   input logic [CNT_W-1:0] dbnc_cnt,
   input logic [CNT_W-1:0] dbnc_thr,
   input logic             set_any
);
   // R1: reset state, sampled away from the edge
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_state: assert (wake_req == 1'b0 && reg_rd_data == 32'h0);
      end
   end

   a_r2_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & MODE_MASK));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |=> $stable(reg_rd_data));

   a_r5_long_codes: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[14:12] >= 3'd5 |-> dbnc_thr == CNT_W'(LEN5));

   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_active |=> dbnc_cnt == '0);

   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_active && dbnc_cnt >= dbnc_thr) |=> dbnc_cnt == $past(dbnc_thr));

   a_r8_rtc: assert property (@(posedge clk) disable iff (!rst_n)
      (rtc_alarm && reg_rd_data[3]) |=> wake_req);

   a_r8_rtt: assert property (@(posedge clk) disable iff (!rst_n)
      (rtt_alarm && reg_rd_data[2]) |=> wake_req);

   a_r8_sup: assert property (@(posedge clk) disable iff (!rst_n)
      (supmon_det && reg_rd_data[1]) |=> wake_req);

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !wake_clr) |=> wake_req);

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_clr && !set_any) |=> !wake_req);

   a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> $past(set_any));
endmodule

bind wkup_dbnc_ctrl wkup_dbnc_ctrl_chk #(.CNT_W(CNT_W), .LEN5(LEN5)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_data (reg_wr_data),
   .reg_rd_data (reg_rd_data),
   .rtc_alarm   (rtc_alarm),
   .rtt_alarm   (rtt_alarm),
   .supmon_det  (supmon_det),
   .wake_clr    (wake_clr),
   .wake_req    (wake_req),
   .pin_active  (pin_active),
   .dbnc_cnt    (dbnc_cnt),
   .dbnc_thr    (dbnc_thr),
   .set_any     (set_any)
);

// File: tb/wkup_dbnc_ctrl_bench.sv
`timescale 1ns/1ps
module wkup_dbnc_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic [1:0]  wkup_pin = '0;
   logic [1:0]  wkup_pin_en = '0;
   logic        rtc_alarm = 1'b0;
   logic        rtt_alarm = 1'b0;
   logic        supmon_det = 1'b0;
   logic        wake_clr = 1'b0;
   logic        wake_req;

   int checks = 0;
   int bad    = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wkup_dbnc_ctrl u_wkup_dbnc_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_data (reg_rd_data),
      .wkup_pin    (wkup_pin),
      .wkup_pin_en (wkup_pin_en),
      .rtc_alarm   (rtc_alarm),
      .rtt_alarm   (rtt_alarm),
      .supmon_det  (supmon_det),
      .wake_clr    (wake_clr),
      .wake_req    (wake_req)
   );

   typedef struct packed {
      logic [2:0]  code;
      logic [16:0] len;
      logic        exp;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VEC [NVEC] = '{
      '{code: 3'd0, len: 17'd1,     exp: 1'b1},
      '{code: 3'd1, len: 17'd2,     exp: 1'b0},
      '{code: 3'd1, len: 17'd3,     exp: 1'b1},
      '{code: 3'd2, len: 17'd31,    exp: 1'b0},
      '{code: 3'd2, len: 17'd32,    exp: 1'b1},
      '{code: 3'd3, len: 17'd511,   exp: 1'b0},
      '{code: 3'd3, len: 17'd512,   exp: 1'b1},
      '{code: 3'd4, len: 17'd4095,  exp: 1'b0},
      '{code: 3'd4, len: 17'd4096,  exp: 1'b1},
      '{code: 3'd5, len: 17'd32767, exp: 1'b0},
      '{code: 3'd5, len: 17'd32768, exp: 1'b1},
      '{code: 3'd6, len: 17'd32768, exp: 1'b1},
      '{code: 3'd7, len: 17'd32767, exp: 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mode(input logic [31:0] v);
      reg_wr_en   = 1'b1;
      reg_wr_data = v;
      step(1);
      reg_wr_en   = 1'b0;
   endtask

   task automatic pulse_clr();
      wake_clr = 1'b1;
      step(1);
      wake_clr = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1: reset state
      chk("R1 reset rd", reg_rd_data, 32'h0);
      chk("R1 reset wake", {31'b0, wake_req}, 32'h0);
      rst_n = 1'b1;
      step(2);

      // R2: only mapped bits stored
      write_mode(32'hFFFF_FFFF);
      chk("R2 mask", reg_rd_data, 32'h0000_700E);
      write_mode(32'h0000_5008);
      chk("R2 readback", reg_rd_data, 32'h0000_5008);
      step(3);
      chk("R2 hold", reg_rd_data, 32'h0000_5008);
      write_mode(32'h0);
      pulse_clr();

      // R4/R5: vector walk over debounce lengths on pin 0
      wkup_pin_en = 2'b01;
      for (int i = 0; i < NVEC; i++) begin
         write_mode({17'b0, VEC[i].code, 12'b0});
         wkup_pin[0] = 1'b1;
         step(int'(VEC[i].len));
         wkup_pin[0] = 1'b0;
         step(4);
         chk((VEC[i].code >= 3'd6) ? "R5 alias code" : "R4 length",
             {31'b0, wake_req}, {31'b0, VEC[i].exp});
         pulse_clr();
         step(3);
      end

      // R3: immediate latency, code 0
      write_mode(32'h0);
      wkup_pin[0] = 1'b1;
      step(2);
      chk("R3 not yet", {31'b0, wake_req}, 32'h0);
      step(1);
      chk("R3 due", {31'b0, wake_req}, 32'h1);
      wkup_pin[0] = 1'b0;
      step(3);
      pulse_clr();
      step(2);

      // R4: code 1 latency, due at N+1 = 4 edges
      write_mode(32'h0000_1000);
      wkup_pin[0] = 1'b1;
      step(4);
      chk("R4 latency early", {31'b0, wake_req}, 32'h0);
      step(1);
      chk("R4 latency due", {31'b0, wake_req}, 32'h1);
      wkup_pin[0] = 1'b0;
      step(3);
      pulse_clr();
      step(2);

      // R6: gap restarts count (code 1)
      wkup_pin[0] = 1'b1; step(2);
      wkup_pin[0] = 1'b0; step(1);
      wkup_pin[0] = 1'b1; step(2);
      wkup_pin[0] = 1'b0; step(5);
      chk("R6 gap", {31'b0, wake_req}, 32'h0);

      // R7: masked pin ignored
      wkup_pin_en = 2'b01;
      wkup_pin[1] = 1'b1; step(10);
      wkup_pin[1] = 1'b0; step(5);
      chk("R7 masked", {31'b0, wake_req}, 32'h0);
      // R7: handover between enabled pins is continuous
      wkup_pin_en = 2'b11;
      wkup_pin = 2'b01; step(2);
      wkup_pin = 2'b10; step(2);
      wkup_pin = 2'b00; step(5);
      chk("R7 or", {31'b0, wake_req}, 32'h1);
      pulse_clr();
      step(3);

      // R8: alarm enables (bit3 rtc, bit2 rtt, bit1 sup)
      write_mode(32'h0000_0008);
      rtt_alarm = 1'b1; supmon_det = 1'b1; step(1);
      rtt_alarm = 1'b0; supmon_det = 1'b0;
      chk("R8 disabled", {31'b0, wake_req}, 32'h0);
      rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
      chk("R8 rtc", {31'b0, wake_req}, 32'h1);
      pulse_clr();
      write_mode(32'h0000_0004);
      rtt_alarm = 1'b1; step(1); rtt_alarm = 1'b0;
      chk("R8 rtt", {31'b0, wake_req}, 32'h1);
      pulse_clr();
      write_mode(32'h0000_0002);
      supmon_det = 1'b1; step(1); supmon_det = 1'b0;
      chk("R8 sup", {31'b0, wake_req}, 32'h1);
      pulse_clr();

      // R9: sticky, clear, set wins over clear
      write_mode(32'h0000_0008);
      rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
      step(4);
      chk("R9 sticky", {31'b0, wake_req}, 32'h1);
      pulse_clr();
      chk("R9 cleared", {31'b0, wake_req}, 32'h0);
      rtc_alarm = 1'b1; wake_clr = 1'b1; step(1);
      wake_clr = 1'b0; rtc_alarm = 1'b0;
      chk("R9 set wins", {31'b0, wake_req}, 32'h1);
      pulse_clr();
      chk("R9 final clear", {31'b0, wake_req}, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule